// File: doc/BRIEF.md
# Blocking Rendezvous Channel

This block joins two thread controllers on the same clock with a one-way channel that stores nothing. The producing controller raises a write request and presents a word. The consuming controller raises a read request. Each side has its own small waiting state machine, and that machine holds its thread until the partner arrives. A word moves only in a cycle where both requests are live. In that cycle both sides get a one-cycle release pulse, and the word is latched into a register on the consuming side.

Arrival order does not matter. Whichever side requests first waits, and the transfer completes in the cycle the other side raises its request. If both requests rise together, the transfer happens at once. After a release, each side spends one cycle in a completion state. During that cycle a request that is still held does not count, so it cannot be mistaken for a new one. To link two controllers in both directions, use two instances. Nothing in the block guards against circular waits between controllers.

Top module: `rendezvous_channel`

## Requirements
- R1: A synchronous active-high reset clears the captured word `rd_data` to zero and returns both sides to idle. After reset, no release is produced until both sides request.
- R2: A transfer happens in a cycle only when `wr_req` and `rd_req` are both 1 and neither side is in the cycle right after its own release. In that cycle `wr_release` is 1. In no other cycle is `wr_release` 1.
- R3: When the writer requests first, the writer side waits with no release for as long as `rd_req` stays 0. The release comes in the same cycle that `rd_req` rises.
- R4: When the reader requests first, the reader side waits with no release for as long as `wr_req` stays 0. The release comes in the same cycle that `wr_req` rises.
- R5: When both requests rise in the same cycle from idle, the transfer completes in that same cycle.
- R6: In the cycle after a transfer, `rd_data` equals the `wr_data` present in the transfer cycle. At all other times `rd_data` holds its value, and `wr_data` has no effect when no transfer happens.
- R7: A release lasts exactly one cycle. If both requests stay at 1 continuously, transfers happen every second cycle, because a request held through the cycle after a release is ignored in that cycle.
- R8: `wr_release` and `rd_release` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Producer request, held until its release is seen |
| wr_data | input | DATA_W | Word offered by the producer |
| wr_release | output | 1 | One-cycle pulse that lets the producer resume |
| rd_req | input | 1 | Consumer request, held until its release is seen |
| rd_data | output | DATA_W | Last word received, registered |
| rd_release | output | 1 | One-cycle pulse that lets the consumer resume |

## Verification
The bench sweeps every pairing of writer and reader arrival delays from zero to five cycles. A design that released the early side on its own request alone, or that added a cycle of latency on the late arrival, would show up as a release in the wrong cycle. Holding both requests high checks the spacing of one transfer every second cycle. A design without the completion cycle would transfer twice on one stale request, and one that stayed blocked would stall. Random arrival timing with changing idle data checks that `rd_data` moves only on a transfer. A mid-run reset must clear a nonzero captured word.

// File: rtl/rdv_pkg.sv
package rdv_pkg;

    typedef enum logic [1:0] {
        SIDE_IDLE = 2'd0,
        SIDE_WAIT = 2'd1,
        SIDE_DONE = 2'd2
    } side_state_e;

    // A side offers itself to the partner only outside its completion cycle.
    function automatic logic side_offers(input side_state_e st, input logic req);
        return req && (st != SIDE_DONE);
    endfunction

    function automatic side_state_e side_next(input side_state_e st,
                                              input logic req,
                                              input logic meet);
        side_state_e nx;
        nx = SIDE_IDLE;
        case (st)
            SIDE_IDLE: nx = meet ? SIDE_DONE : (req ? SIDE_WAIT : SIDE_IDLE);
            SIDE_WAIT: nx = meet ? SIDE_DONE : (req ? SIDE_WAIT : SIDE_IDLE);
            SIDE_DONE: nx = SIDE_IDLE;
            default:   nx = SIDE_IDLE;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/rdv_side.sv
module rdv_side
    import rdv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic partner_offer,
    output logic offer,
    output logic release_pulse
);
    side_state_e state_q;
    logic        meet;

    assign offer         = side_offers(state_q, req);
    assign meet          = offer && partner_offer;
    assign release_pulse = meet;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SIDE_IDLE;
        end else begin
            state_q <= side_next(state_q, req, meet);
        end
    end
endmodule

// File: rtl/rdv_capture.sv
module rdv_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam logic [DATA_W-1:0] ZERO = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= ZERO;
        end else if (load) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/rendezvous_channel.sv
module rendezvous_channel #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_release,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_release
);
    localparam int SIDES = 2;
    localparam int PROD  = 0;
    localparam int CONS  = 1;

    logic [SIDES-1:0] req_v;
    logic [SIDES-1:0] offer_v;
    logic [SIDES-1:0] rel_v;

    assign req_v[PROD] = wr_req;
    assign req_v[CONS] = rd_req;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        rdv_side u_side (
            .clk           (clk),
            .rst           (rst),
            .req           (req_v[s]),
            .partner_offer (offer_v[SIDES-1-s]),
            .offer         (offer_v[s]),
            .release_pulse (rel_v[s])
        );
    end

    assign wr_release = rel_v[PROD];
    assign rd_release = rel_v[CONS];

    rdv_capture #(.DATA_W(DATA_W)) u_capture (
        .clk  (clk),
        .rst  (rst),
        .load (rel_v[CONS]),
        .din  (wr_data),
        .dout (rd_data)
    );
endmodule

// File: rtl/rdv_checker.sv
module rdv_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_req,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_release,
    input logic              rd_req,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_release
);
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (rd_data == '0));

    p_release_needs_both_r2: assert property (@(posedge clk) disable iff (rst)
        wr_release |-> (wr_req && rd_req));

    p_release_pair_r8: assert property (@(posedge clk) disable iff (rst)
        wr_release == rd_release);

    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        rd_release |=> (rd_data == $past(wr_data)));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_release |=> $stable(rd_data));

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        wr_release |=> !wr_release);
endmodule

bind rendezvous_channel rdv_checker #(.DATA_W(DATA_W)) u_rdv_checker (
    .clk        (clk),
    .rst        (rst),
    .wr_req     (wr_req),
    .wr_data    (wr_data),
    .wr_release (wr_release),
    .rd_req     (rd_req),
    .rd_data    (rd_data),
    .rd_release (rd_release)
);

// File: tb/rendezvous_channel_bench.sv
module rendezvous_channel_bench;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_req = 1'b0;
    logic          rd_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_release;
    logic          rd_release;
    logic [DW-1:0] rd_data;

    int            checks = 0;
    int            errors = 0;
    logic [DW-1:0] exp_data = '0;
    bit            side_cool = 1'b0;

    always #5 clk = ~clk;

    rendezvous_channel #(.DATA_W(DW)) u_rendezvous_channel (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_data(wr_data), .wr_release(wr_release),
        .rd_req(rd_req), .rd_data(rd_data), .rd_release(rd_release)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One clock cycle: check captured word, drive, check releases, update model.
    task automatic cycle(input bit w, input bit r, input logic [DW-1:0] d, output bit go);
        @(negedge clk);
        chk(rd_data === exp_data, "R6", "rd_data", rd_data, exp_data);
        wr_req  = w;
        rd_req  = r;
        wr_data = d;
        #4;
        go = w && r && !side_cool;
        chk(wr_release === go, "R2", "wr_release", wr_release, go);
        chk(rd_release === wr_release, "R8", "rd_release", rd_release, wr_release);
        if (go) exp_data = d;
        side_cool = go;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_req = 1'b0; rd_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_data = '0;
        side_cool = 1'b0;
        #1;
        chk(rd_data === '0, "R1", "rd_data after reset", rd_data, 0);
        chk(wr_release === 1'b0 && rd_release === 1'b0, "R1", "release after reset",
            {wr_release, rd_release}, 0);
    endtask

    task automatic run_pair(input int wd, input int rl);
        logic [DW-1:0] d;
        bit go;
        int got;
        string tag;
        d   = DW'($urandom_range(1, 255));
        got = -1;
        for (int c = 0; c < 12 && got < 0; c++) begin
            cycle(c >= wd, c >= rl, (c >= wd) ? d : DW'($urandom), go);
            if (go) got = c;
        end
        tag = (wd < rl) ? "R3" : ((wd > rl) ? "R4" : "R5");
        chk(got == ((wd > rl) ? wd : rl), tag, "release cycle", got, (wd > rl) ? wd : rl);
        cycle(1'b0, 1'b0, DW'($urandom), go);
        chk(exp_data === d, "R6", "word delivered", exp_data, d);
        cycle(1'b0, 1'b0, DW'($urandom), go);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        bit go;
        int n;
        bit ww, rw;
        logic [DW-1:0] wd;
        do_reset();

        // R1: single-side requests after reset give no release.
        cycle(1'b1, 1'b0, 8'h5A, go);
        chk(go == 1'b0 && wr_release === 1'b0, "R1", "lone writer", wr_release, 0);
        cycle(1'b0, 1'b0, 8'h00, go);

        // R3/R4/R5: arrival-order sweep.
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                run_pair(a, b);

        // R7: both requests held continuously transfer every second cycle.
        n = 0;
        for (int k = 0; k < 10; k++) begin
            cycle(1'b1, 1'b1, DW'(k + 16), go);
            if (wr_release === 1'b1) n++;
        end
        chk(n == 5, "R7", "held-request transfer count", n, 5);
        cycle(1'b0, 1'b0, 8'h00, go);
        cycle(1'b0, 1'b0, 8'h00, go);

        // R1: mid-run reset clears a nonzero word.
        chk(rd_data !== '0, "R1", "word nonzero before reset", rd_data, 1);
        do_reset();

        // Random arrival timing; idle data changes freely (R6).
        ww = 0; rw = 0; wd = '0;
        for (int k = 0; k < 3000; k++) begin
            if (!ww && ($urandom % 3 == 0)) begin ww = 1; wd = DW'($urandom); end
            if (!rw && ($urandom % 3 == 0)) rw = 1;
            cycle(ww, rw, ww ? wd : DW'($urandom), go);
            if (go) begin
                ww = ($urandom % 2 == 0);
                if (ww) wd = DW'($urandom);
                rw = ($urandom % 2 == 0);
            end
        end
        cycle(1'b0, 1'b0, 8'h00, go);
        cycle(1'b0, 1'b0, 8'h00, go);
        finish_run();
    end
endmodule